// File: doc/BRIEF.md
# Fractional-aligned multiply-to-accumulator unit

This unit multiplies two signed 16-bit quantities and deposits the 32-bit product into a wide accumulator in a fractional position. It takes the least significant halves of two 32-bit register operands and treats each as a two's-complement integer. The product is placed so that its least significant bit sits at accumulator bit 16. The sixteen bits below that are cleared, and every bit above the product is filled with the product's sign. Two 72-bit accumulators are held inside the unit and can be read at any time.

A mode input picks one of two behaviours. In the single-destination (legacy) form, every result goes to accumulator 0. In the dual-destination form, a one-bit selector picks accumulator 0 or accumulator 1. An operation is started with a one-cycle strobe. The operands are captured on that edge and the accumulator is written on the next one, with a one-cycle done pulse alongside the write. A new operation may start on every cycle. The unit keeps no condition flags.

Top module: `frac_mul_acc`

## Requirements
- R1: Only bits 15:0 of each operand take part in the multiply, each read as a signed two's-complement value. Bits 31:16 of both operands have no effect on the result.
- R2: Accumulator bits 47:16 of the destination hold the 32-bit signed product after the write, so product bit 0 sits at accumulator bit 16.
- R3: Every write leaves destination accumulator bits 15:0 at zero, whatever value they held before.
- R4: Destination accumulator bits 71:48 are all copies of product bit 31 (accumulator bit 47) after every write, in both modes.
- R5: With dual_mode_i = 1, acc_sel_i = 0 writes accumulator 0 and acc_sel_i = 1 writes accumulator 1.
- R6: With dual_mode_i = 0, the result always goes to accumulator 0 and acc_sel_i has no effect.
- R7: The accumulator that is not written keeps its previous contents unchanged.
- R8: An operation whose start_i is sampled at clock edge k updates the accumulator at edge k+1. done_o is high for exactly the cycle after edge k+1. Starts on consecutive cycles each complete in order, one per cycle.
- R9: A synchronous active-high reset clears both accumulators to zero and holds done_o low.
- R10: Multiplying -32768 by -32768 yields +2^30 in bits 47:16, with bits 71:48 and bits 15:0 all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle strobe that launches an operation |
| src_a_i | input | 32 | First operand; only bits 15:0 are used |
| src_b_i | input | 32 | Second operand; only bits 15:0 are used |
| acc_sel_i | input | 1 | Destination select in dual mode (0: acc 0, 1: acc 1) |
| dual_mode_i | input | 1 | 1: dual-destination form; 0: single-destination form |
| acc0_o | output | 72 | Contents of accumulator 0 |
| acc1_o | output | 72 | Contents of accumulator 1 |
| done_o | output | 1 | One-cycle pulse that accompanies each accumulator write |

## Verification
The bench builds the unit with its default widths: 32-bit operands, 16-bit multiply halves, 72-bit accumulators and a 16-bit fractional shift. These values put both extremes of the signed operand range within reach, including the single overflow-prone square. They also leave a 24-bit sign-extension field whose fill can be checked for both product signs. Junk in the upper operand halves, back-to-back starts that alternate between accumulators, and a reset after nonzero contents complete the coverage.

// File: rtl/fma_pkg.sv
package fma_pkg;
    parameter int unsigned OPW     = 32;
    parameter int unsigned HALFW   = 16;
    parameter int unsigned ACCW    = 72;
    parameter int unsigned FRAC_SH = 16;
    parameter int unsigned NUM_ACC = 2;

    localparam int unsigned PRODW  = 2 * HALFW;
    localparam int unsigned SGNW   = ACCW - FRAC_SH - PRODW;
    localparam int unsigned SELW   = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1;

    typedef struct packed {
        logic                    vld;
        logic signed [HALFW-1:0] opa;
        logic signed [HALFW-1:0] opb;
        logic [SELW-1:0]         dst;
    } opreg_t;

    typedef struct packed {
        logic [NUM_ACC-1:0][ACCW-1:0] acc;
        logic                         done;
    } bank_t;
endpackage

// File: rtl/fma_opstage.sv
module fma_opstage
    import fma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [HALFW-1:0] lo_a_i,
    input  logic [HALFW-1:0] lo_b_i,
    input  logic             acc_sel_i,
    input  logic             dual_mode_i,
    output opreg_t           op_o
);
    opreg_t op_d, op_q;

    always_comb begin
        op_d     = op_q;
        op_d.vld = start_i;
        if (start_i) begin
            op_d.opa = lo_a_i;
            op_d.opb = lo_b_i;
            // single-destination form always targets accumulator 0
            op_d.dst = dual_mode_i ? SELW'(acc_sel_i) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) op_q <= '0;
        else     op_q <= op_d;
    end

    assign op_o = op_q;

    p_capture_r8: assert property (@(posedge clk) disable iff (rst)
        start_i |=> op_q.vld);
    p_legacy_dst_r6: assert property (@(posedge clk) disable iff (rst)
        (start_i && !dual_mode_i) |=> (op_q.dst == '0));
endmodule

// File: rtl/fma_align.sv
module fma_align
    import fma_pkg::*;
(
    input  logic signed [HALFW-1:0] opa_i,
    input  logic signed [HALFW-1:0] opb_i,
    output logic [ACCW-1:0]         word_o
);
    logic signed [PRODW-1:0] prod_d;

    always_comb begin
        prod_d = PRODW'(opa_i) * PRODW'(opb_i);
    end

    generate
        if (FRAC_SH > 0) begin : g_frac
            assign word_o = {{SGNW{prod_d[PRODW-1]}}, prod_d, {FRAC_SH{1'b0}}};
        end else begin : g_int
            assign word_o = {{SGNW{prod_d[PRODW-1]}}, prod_d};
        end
    endgenerate

    always_comb begin
        if ((opa_i == {1'b1, {(HALFW-1){1'b0}}}) && (opb_i == {1'b1, {(HALFW-1){1'b0}}}))
            p_min_square_r10: assert (prod_d[PRODW-1] == 1'b0);
    end
endmodule

// File: rtl/fma_accbank.sv
module fma_accbank
    import fma_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en_i,
    input  logic [SELW-1:0]              wr_sel_i,
    input  logic [ACCW-1:0]              wr_word_i,
    output logic [NUM_ACC-1:0][ACCW-1:0] acc_o,
    output logic                         done_o
);
    bank_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = wr_en_i;
        for (int i = 0; i < NUM_ACC; i++) begin
            if (wr_en_i && (wr_sel_i == SELW'(i)))
                st_d.acc[i] = wr_word_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc_o  = st_q.acc;
    assign done_o = st_q.done;

    generate
        for (genvar g = 0; g < NUM_ACC; g++) begin : g_chk
            p_low_zero_r3: assert property (@(posedge clk) disable iff (rst)
                (wr_en_i && wr_sel_i == SELW'(g)) |=> (st_q.acc[g][FRAC_SH-1:0] == '0));
            p_sign_fill_r4: assert property (@(posedge clk) disable iff (rst)
                (wr_en_i && wr_sel_i == SELW'(g)) |=>
                ((st_q.acc[g][ACCW-1:FRAC_SH+PRODW-1] == '0) ||
                 (st_q.acc[g][ACCW-1:FRAC_SH+PRODW-1] == '1)));
            p_keep_other_r7: assert property (@(posedge clk) disable iff (rst)
                !(wr_en_i && wr_sel_i == SELW'(g)) |=> $stable(st_q.acc[g]));
        end
    endgenerate
endmodule

// File: rtl/frac_mul_acc.sv
module frac_mul_acc
    import fma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [OPW-1:0]  src_a_i,
    input  logic [OPW-1:0]  src_b_i,
    input  logic            acc_sel_i,
    input  logic            dual_mode_i,
    output logic [ACCW-1:0] acc0_o,
    output logic [ACCW-1:0] acc1_o,
    output logic            done_o
);
    opreg_t                       op_q;
    logic [ACCW-1:0]              word_d;
    logic [NUM_ACC-1:0][ACCW-1:0] acc_q;
    logic                         unused_hi;

    assign unused_hi = ^{src_a_i[OPW-1:HALFW], src_b_i[OPW-1:HALFW]};

    fma_opstage u_opstage (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .lo_a_i      (src_a_i[HALFW-1:0]),
        .lo_b_i      (src_b_i[HALFW-1:0]),
        .acc_sel_i   (acc_sel_i),
        .dual_mode_i (dual_mode_i),
        .op_o        (op_q)
    );

    fma_align u_align (
        .opa_i  (op_q.opa),
        .opb_i  (op_q.opb),
        .word_o (word_d)
    );

    fma_accbank u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (op_q.vld),
        .wr_sel_i  (op_q.dst),
        .wr_word_i (word_d),
        .acc_o     (acc_q),
        .done_o    (done_o)
    );

    assign acc0_o = acc_q[0];
    assign acc1_o = acc_q[1];

    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        start_i |-> ##2 done_o);
    p_no_spurious_done_r8: assert property (@(posedge clk) disable iff (rst)
        !start_i |-> ##2 !done_o);
    p_legacy_acc1_r6: assert property (@(posedge clk) disable iff (rst)
        (start_i && !dual_mode_i) |-> ##2 $stable(acc1_o));
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (acc0_o == '0 && acc1_o == '0 && !done_o));
endmodule

// File: tb/frac_mul_acc_tb.sv
module frac_mul_acc_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] src_a_i = '0;
    logic [31:0] src_b_i = '0;
    logic        acc_sel_i = 1'b0;
    logic        dual_mode_i = 1'b0;
    logic [71:0] acc0_o, acc1_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    logic [71:0] e0 = '0;
    logic [71:0] e1 = '0;

    always #4 clk = ~clk;

    frac_mul_acc u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .src_a_i(src_a_i),
        .src_b_i(src_b_i), .acc_sel_i(acc_sel_i), .dual_mode_i(dual_mode_i),
        .acc0_o(acc0_o), .acc1_o(acc1_o), .done_o(done_o)
    );

    function automatic logic [71:0] ref_word(input logic [31:0] a, input logic [31:0] b);
        logic signed [15:0] x, y;
        logic signed [31:0] p;
        logic signed [71:0] w;
        x = a[15:0];
        y = b[15:0];
        p = 32'(x) * 32'(y);
        w = 72'(p);
        return w <<< 16;
    endfunction

    task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_accs(input string req);
        chk(req, acc0_o, e0);
        chk(req, acc1_o, e1);
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          input logic sel, input logic dual);
        @(negedge clk);
        start_i = 1'b1; src_a_i = a; src_b_i = b; acc_sel_i = sel; dual_mode_i = dual;
        @(negedge clk);
        start_i = 1'b0; src_a_i = $urandom; src_b_i = $urandom;
        chk("R8 done low one cycle after start", 72'(done_o), 72'(0));
        if (dual && sel) e1 = ref_word(a, b);
        else             e0 = ref_word(a, b);
        @(negedge clk);
        chk("R8 done high two cycles after start", 72'(done_o), 72'(1));
    endtask

    task automatic t_reset();
        chk("R9 reset acc0", acc0_o, '0);
        chk("R9 reset acc1", acc1_o, '0);
        chk("R9 reset done", 72'(done_o), 72'(0));
    endtask

    task automatic t_basic();
        run_op(32'h0000_0003, 32'h0000_0005, 1'b1, 1'b1);
        chk_accs("R2 positive product");
        chk("R2 field", 72'(acc1_o[47:16]), 72'(15));
        run_op(32'h0000_0007, 32'h0000_FFFD, 1'b1, 1'b1);
        chk_accs("R2 negative product");
        chk("R4 sign fill ones", 72'(acc1_o[71:48]), 72'(24'hFFFFFF));
        chk("R3 low bits zero", 72'(acc1_o[15:0]), 72'(0));
        run_op(32'h0000_7FFF, 32'h0000_8000, 1'b1, 1'b1);
        chk_accs("R2 extreme mixed sign");
        run_op(32'h0000_1234, 32'h0000_0000, 1'b1, 1'b1);
        chk_accs("R4 zero product sign fill");
    endtask

    task automatic t_upper_ignored();
        run_op(32'hABCD_0003, 32'h1234_FFFE, 1'b0, 1'b1);
        chk("R1 upper bits ignored", acc0_o, ref_word(32'h3, 32'hFFFE));
        chk_accs("R1 signed low halves");
        run_op(32'hFFFF_0002, 32'h0000_0002, 1'b0, 1'b1);
        chk("R1 upper ones ignored", 72'(acc0_o[47:16]), 72'(4));
    endtask

    task automatic t_dual_select();
        run_op(32'h0000_0100, 32'h0000_0100, 1'b0, 1'b1);
        chk_accs("R5 sel0 writes acc0, R7 acc1 kept");
        run_op(32'h0000_FF00, 32'h0000_0011, 1'b1, 1'b1);
        chk_accs("R5 sel1 writes acc1, R7 acc0 kept");
    endtask

    task automatic t_legacy();
        run_op(32'h0000_0009, 32'h0000_FFFF, 1'b1, 1'b0);
        chk_accs("R6 legacy ignores sel, R7 acc1 kept");
        chk("R4 legacy sign fill through 71", 72'(acc0_o[71:48]), 72'(24'hFFFFFF));
        run_op(32'h0000_0040, 32'h0000_0002, 1'b0, 1'b0);
        chk_accs("R6 legacy sel0");
    endtask

    task automatic t_corner();
        run_op(32'h0000_8000, 32'h0000_8000, 1'b0, 1'b1);
        chk("R10 product field", 72'(acc0_o[47:16]), 72'(32'h4000_0000));
        chk("R10 sign field zero", 72'(acc0_o[71:48]), 72'(0));
        chk("R10 low zero", 72'(acc0_o[15:0]), 72'(0));
    endtask

    task automatic t_backtoback();
        logic [71:0] wa, wb, wc;
        wa = ref_word(32'h0000_0011, 32'h0000_0022);
        wb = ref_word(32'h0000_FFF0, 32'h0000_0003);
        wc = ref_word(32'h0000_0101, 32'h0000_FF00);
        @(negedge clk);
        start_i = 1'b1; dual_mode_i = 1'b1;
        src_a_i = 32'h11; src_b_i = 32'h22; acc_sel_i = 1'b0;
        @(negedge clk);
        src_a_i = 32'hFFF0; src_b_i = 32'h3; acc_sel_i = 1'b1;
        @(negedge clk);
        src_a_i = 32'h0101; src_b_i = 32'hFF00; acc_sel_i = 1'b0;
        chk("R8 first result", acc0_o, wa);
        chk("R8 done op1", 72'(done_o), 72'(1));
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 second result", acc1_o, wb);
        chk("R8 R7 acc0 held", acc0_o, wa);
        chk("R8 done op2", 72'(done_o), 72'(1));
        @(negedge clk);
        chk("R8 third result", acc0_o, wc);
        chk("R8 done op3", 72'(done_o), 72'(1));
        @(negedge clk);
        chk("R8 done drops", 72'(done_o), 72'(0));
        e0 = wc; e1 = wb;
    endtask

    task automatic t_reset_clear();
        chk("R9 accs nonzero before reset", 72'(acc0_o != '0 && acc1_o != '0), 72'(1));
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        e0 = '0; e1 = '0;
        chk_accs("R9 reset clears");
        chk("R9 done low after reset", 72'(done_o), 72'(0));
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_upper_ignored();
        t_dual_select();
        t_legacy();
        t_corner();
        t_backtoback();
        t_reset_clear();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule